// File: doc/BRIEF.md
# PCM Voice Engine Host Port Decoder

This block sits between a host processor bus and the voice engine of a 28-channel PCM sound generator. The host reaches the engine through only three byte-wide locations. It names a slot at one location, names a register at a second, and then writes data at the third. Each data write leaves the block as a one-cycle strobe that carries the internal channel index, the register number and the data byte.

Slot codes run from 0 to 31. They are grouped in fours of eight, and the last code of each group of eight has no channel. The decoder folds the valid codes onto channels 0 to 27. While an unusable code is selected, data writes are dropped.

The host can read back both selections. A status byte carries the engine's busy flag, so a driver can poll it before each access. The flag is only a hint: the decoder takes writes whether or not the engine reports busy.

Top module: `pcm_host_port`

## Requirements
- R1: During and after reset, `wr_stb` is low, the slot selection is code 0 (channel 0), and the register selection is 0. Reads of offsets 1 and 2 return 0.
- R2: A write with `bus_sel`=1, `bus_wr`=1 and `bus_addr`=0 while a valid slot is selected raises `wr_stb` for exactly one cycle, on the clock edge after the write edge. In that cycle, `wr_reg` holds the register selection and `wr_data` holds the written byte.
- R3: For a valid slot code c, `wr_chan` equals 7*(c>>3) + (c&7). This maps codes 0–6 to channels 0–6, 8–14 to 7–13, 16–22 to 14–20, and 24–30 to 21–27.
- R4: Codes whose low three bits are 7 (7, 15, 23, 31) are invalid. While one of them is selected, data writes produce no strobe. This lasts until a valid code is written to offset 1.
- R5: A write to offset 1 stores bits 4..0 of the byte as the slot code. A write to offset 2 stores the whole byte as the register number. Data writes leave both selections unchanged, so repeated data writes reach the same target.
- R6: A read (`bus_sel`=1, `bus_rd`=1) of offset 0 returns `eng_busy` in bit 0 and zero in bits 7..1, with no clock delay.
- R7: A read of offset 1 returns the stored slot code, with bits 7..5 zero. A read of offset 2 returns the stored register number. Both reads are combinational.
- R8: A data write made while `eng_busy` is high is still strobed, exactly as in R2.
- R9: Writes to offset 3, and any write with `bus_sel` low, change no selection and produce no strobe. Reads of offset 3, and any access without `bus_sel` and `bus_rd` both high, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Chip select for the current bus cycle |
| bus_wr | input | 1 | Write enable, sampled on the rising clock edge |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | 2 | Port offset (0 data/status, 1 slot, 2 register) |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational |
| eng_busy | input | 1 | Busy flag from the voice engine |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_chan | output | 5 | Internal channel index, 0 to 27 |
| wr_reg | output | 8 | Register number for the strobe |
| wr_data | output | 8 | Data byte for the strobe |

## Verification
The strobe and its channel, register and data fields are due one clock after the edge that samples the data write. Slot and register selections take effect from the edge that samples their write, so a data write in the next cycle already uses them. Read data is due in the same cycle as the read, with no edge in between. The bench drives its inputs on falling edges and updates its reference model on rising edges. It compares the registered outputs on every falling edge, and checks read data a nanosecond after setting up the read, so each result is sampled in the cycle it is due.

// File: rtl/pcm_host_port.sv
module pcm_host_port #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 5,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  output logic              wr_stb,
  output logic [CHAN_W-1:0] wr_chan,
  output logic [DATA_W-1:0] wr_reg,
  output logic [DATA_W-1:0] wr_data
);
  localparam int GRP_W = SLOT_W - 3;

  logic [SLOT_W-1:0] slot_q;
  logic [DATA_W-1:0] reg_q;
  logic              slot_ok;
  logic [CHAN_W-1:0] chan_idx;
  logic              wr_cyc;

  assign wr_cyc   = bus_sel & bus_wr;
  assign slot_ok  = slot_q[2:0] != 3'd7;
  assign chan_idx = CHAN_W'({slot_q[SLOT_W-1:3], 3'b000}) - CHAN_W'(slot_q[SLOT_W-1:3])
                  + CHAN_W'(slot_q[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      reg_q  <= '0;
    end else if (wr_cyc) begin
      if (bus_addr == 2'd1) slot_q <= bus_wdata[SLOT_W-1:0];
      if (bus_addr == 2'd2) reg_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_chan <= '0;
      wr_reg  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= wr_cyc && bus_addr == 2'd0 && slot_ok;
      if (wr_cyc && bus_addr == 2'd0 && slot_ok) begin
        wr_chan <= chan_idx;
        wr_reg  <= reg_q;
        wr_data <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      case (bus_addr)
        2'd0:    bus_rdata = {{(DATA_W-1){1'b0}}, eng_busy};
        2'd1:    bus_rdata = DATA_W'(slot_q);
        2'd2:    bus_rdata = reg_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [GRP_W-1:0] unused_grp;
  assign unused_grp = slot_q[SLOT_W-1:3];
endmodule

// File: rtl/pcm_host_port_chk.sv
module pcm_host_port_chk #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 5,
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_busy,
  input logic              wr_stb,
  input logic [CHAN_W-1:0] wr_chan,
  input logic [SLOT_W-1:0] slot_q
);
  AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(bus_sel && bus_wr && bus_addr == 2'd0)); // R2
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_chan < CHAN_W'(28)); // R3
  AST_NO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd0 && slot_q[2:0] == 3'd7) |=> !wr_stb); // R4
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == 2'd0) |-> bus_rdata == DATA_W'(eng_busy)); // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd0 && slot_q[2:0] != 3'd7 && eng_busy) |=> wr_stb); // R8
endmodule

bind pcm_host_port pcm_host_port_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .eng_busy(eng_busy), .wr_stb(wr_stb),
  .wr_chan(wr_chan), .slot_q(slot_q)
);

// File: tb/tb_pcm_host_port.sv
`timescale 1ns/1ps
module tb_pcm_host_port;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0, eng_busy = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, wr_reg, wr_data;
  logic [4:0] wr_chan;
  logic wr_stb;
  int total = 0, bad = 0;
  bit done = 0;

  int m_slot = 0, m_reg = 0;
  int e_stb = 0, e_chan = 0, e_reg = 0, e_data = 0;

  pcm_host_port dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_reg = 0; e_stb = 0; e_chan = 0; e_reg = 0; e_data = 0;
    end else begin
      e_stb = 0;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 0 && m_slot % 8 != 7) begin
          e_stb = 1; e_chan = (m_slot / 8) * 7 + m_slot % 8; e_reg = m_reg; e_data = bus_wdata;
        end else if (bus_addr == 1) m_slot = bus_wdata % 32;
        else if (bus_addr == 2) m_reg = bus_wdata;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 strobe", wr_stb, e_stb);
    if (e_stb) begin
      chk("R3 channel", wr_chan, e_chan);
      chk("R2 register", wr_reg, e_reg);
      chk("R2 data", wr_data, e_data);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, string tag, input int exp);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = 2'(a);
    #1 chk(tag, bus_rdata, exp);
    bus_sel = 0; bus_rd = 0;
  endtask

  initial begin
    #(200000 * 5);
    chk("watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    chk("R1 strobe in reset", wr_stb, 0);
    @(negedge clk); rst_n = 1;
    rd(1, "R1 slot after reset", 0);
    rd(2, "R1 reg after reset", 0);
    wr(0, 8'h11);                      // R1/R3: channel 0 from reset
    for (int c = 0; c < 32; c++) begin // R3 sweep, R4 invalid codes
      wr(1, c); wr(2, c + 8'h40); wr(0, c ^ 8'hA5);
      rd(1, "R7 slot readback", c);
      rd(2, "R7 reg readback", c + 8'h40);
    end
    wr(1, 15); wr(0, 1); wr(0, 2);     // R4 stays blocked
    chk("R4 no strobe on invalid", wr_stb, 0);
    wr(1, 8); wr(0, 3);                // valid again -> channel 7
    wr(2, 9); wr(0, 4); wr(0, 5); wr(0, 6); // R5 repeated target
    rd(1, "R5 slot kept", 8);
    rd(2, "R5 reg kept", 9);
    wr(1, 8'hE5);
    rd(1, "R7 upper bits dropped", 5);
    eng_busy = 1;
    rd(0, "R6 status busy", 1);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h77;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    chk("R8 strobe while busy", wr_stb, 1);
    eng_busy = 0;
    rd(0, "R6 status idle", 0);
    wr(3, 8'h1F);                      // R9 offset 3 ignored
    @(negedge clk); bus_sel = 0; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h03;
    @(negedge clk); bus_wr = 0;
    chk("R9 no strobe", wr_stb, 0);
    rd(1, "R9 slot unchanged", 5);
    rd(3, "R9 offset 3 reads zero", 0);
    @(negedge clk); bus_sel = 0; bus_rd = 1; bus_addr = 1;
    #1 chk("R9 unselected read zero", bus_rdata, 0);
    bus_rd = 0;
    wr(1, 31); wr(0, 8);
    chk("R4 code 31 blocked", wr_stb, 0);
    wr(1, 30); wr(0, 9);               // channel 27
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule